// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer wrapped around a 10-bit successive-approximation converter. Software starts a conversion by writing the control register (continuous-mode bit, input channel, output format). The controller derives a conversion tick from either the bus clock or an alternate reference tick, divided by a programmable prescaler. It then walks the binary search MSB first. It presents each trial code to the external DAC and reads back the comparator decision. When it finishes, it writes the formatted result into a 16-bit data register, seen as a high byte and a low byte, and raises a completion flag.

The conversion tick is a one-bus-cycle enable, not a derived clock. The prescaler keeps running across control writes, so the first tick after a write can arrive after anywhere from one bus cycle to a full tick period. That partial first period is why a conversion lasts between 16 and 17 tick periods. The sequencer states are:
- IDLE: no conversion.
- ALIGN: the partial first period, waiting for the first tick after a write.
- SAMPLE: one tick.
- RESOLVE: one tick per result bit.
- SETTLE: four ticks.
- XFER: one tick, during which the result is stored.

The transitions are:
- Any state goes to ALIGN on a control write.
- ALIGN goes to SAMPLE on a tick.
- SAMPLE goes to RESOLVE on a tick.
- RESOLVE goes to SETTLE on the tick that resolves bit 0.
- SETTLE goes to XFER on its fourth tick.
- XFER goes to SAMPLE in continuous mode, or to IDLE otherwise.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A pulse on `ctl_wr` abandons any conversion in progress, clears `coco` on the next cycle and starts a new conversion. The data register keeps its old contents until that new conversion stores.
- R2: With P bus cycles per conversion tick, `coco` is set between 16·P+1 and 17·P bus cycles after the write edge. With the bus clock selected and a divide of 1, this is exactly 17 cycles.
- R3: `clk_sel`=0 uses every bus cycle as the tick source and `clk_sel`=1 uses the `ref_tick` pulses. `prescale` codes 0 to 4 divide the source by 1, 2, 4, 8 and 16; codes 5 to 7 divide by 16.
- R4: The stored 10-bit result R is the largest code C for which the comparator reports input ≥ C. Trial codes are resolved MSB first.
- R5: In continuous mode (`ctl_cont`=1 at the write), the next conversion starts with no partial period, so completions are exactly 16·P cycles apart. Each result overwrites the data register whether or not it was read.
- R6: A write with `ctl_cont`=0 ends continuous operation after the single conversion it starts; `busy` then falls.
- R7: `coco` is set at the end of each conversion and cleared by a `data_rd` pulse. A read in the same cycle as a completion leaves `coco` set.
- R8: Format code 0 (left): `res_hi`=R[9:2], `res_lo`={R[1:0],000000}.
- R9: Format code 1 (right): `res_hi`={000000,R[9:8]}, `res_lo`=R[7:0].
- R10: Format code 2 (signed left): `res_hi`={~R[9],R[8:2]}, `res_lo`={R[1:0],000000}.
- R11: Format code 3 (8-bit truncated): `res_hi`=0, `res_lo`=R[9:2].
- R12: After reset and after a single conversion, `busy` is low and the data register and `coco` hold their values until the next write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | Alternate reference clock as a one-cycle enable |
| clk_sel | input | 1 | 0 = bus clock source, 1 = reference tick source |
| prescale | input | PRE_W | Divide code for the tick source |
| ctl_wr | input | 1 | Control register write strobe (starts a conversion) |
| ctl_cont | input | 1 | Continuous-mode bit, captured on write |
| ctl_chan | input | CH_W | Channel number, captured on write |
| ctl_fmt | input | 2 | Result format code, captured on write |
| data_rd | input | 1 | Data register read strobe |
| cmp_in | input | 1 | Comparator: 1 when input ≥ `dac_code` |
| dac_code | output | 10 | Trial code for the DAC |
| chan_sel | output | CH_W | Channel for the input multiplexer |
| sample_en | output | 1 | High during the sample period |
| busy | output | 1 | Sequencer not idle |
| coco | output | 1 | Conversion complete flag |
| res_hi | output | 8 | Data register high byte |
| res_lo | output | 8 | Data register low byte |

## Verification
The bench builds the block with its default parameters: a 3-bit channel, four settle ticks, a 3-bit prescale code and a largest divide of 16. These bring the clamped prescale codes and the exact 17-cycle length at divide 1 within reach. The reference tick is driven once every three bus cycles, which makes the partial first period vary with the alternate source as well. A divide of 2 makes the continuous-mode spacing and the same-cycle read/completion collision short enough to place on exact bus edges.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    localparam int RES_W  = 10;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = DATA_W - RES_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_SAMPLE,
        ST_RESOLVE,
        ST_SETTLE,
        ST_XFER
    } seq_state_t;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'd0,
        FMT_RIGHT = 2'd1,
        FMT_SLEFT = 2'd2,
        FMT_TRUNC = 2'd3
    } fmt_t;

    function automatic logic [DATA_W-1:0] pack_result(input fmt_t f, input logic [RES_W-1:0] r);
        logic [DATA_W-1:0] v;
        case (f)
            FMT_LEFT:  v = {r, {PAD_W{1'b0}}};
            FMT_RIGHT: v = {{PAD_W{1'b0}}, r};
            FMT_SLEFT: v = {~r[RES_W-1], r[RES_W-2:0], {PAD_W{1'b0}}};
            FMT_TRUNC: v = {{(DATA_W-BYTE_W){1'b0}}, r[RES_W-1 -: BYTE_W]};
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int PRE_W   = 3,
    parameter int MAX_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sel,
    input  logic             ref_tick,
    input  logic [PRE_W-1:0] prescale,
    output logic             adc_tick
);
    localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

    logic             src_tick;
    logic [PRE_W-1:0] log_sel;
    logic [CNT_W-1:0] div_last;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        src_tick = clk_sel ? ref_tick : 1'b1;
        log_sel  = (prescale > PRE_W'(MAX_LOG)) ? PRE_W'(MAX_LOG) : prescale;
        div_last = CNT_W'((32'd1 << log_sel) - 32'd1);
        adc_tick = src_tick && (cnt_q >= div_last);
    end

    // free-running: a control write does not realign it, giving the partial first period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (src_tick) begin
            cnt_q <= (cnt_q >= div_last) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_idle_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_tick |=> $stable(cnt_q));

    assert_tick_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_tick |=> (cnt_q == '0));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_adc_pkg::*;
#(
    parameter int CH_W         = 3,
    parameter int SETTLE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_tick,
    input  logic             start,
    input  logic             cont_in,
    input  logic [CH_W-1:0]  chan_in,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  chan_sel,
    output logic             sample_en,
    output logic             busy,
    output logic             done
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int SET_W = $clog2(SETTLE_TICKS + 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] bit_q;
    logic [SET_W-1:0] set_q;
    logic [RES_W-1:0] acc_q;
    logic             cont_q;
    logic [CH_W-1:0]  chan_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ALIGN;
        end else if (adc_tick) begin
            unique case (state_q)
                ST_IDLE:    begin end
                ST_ALIGN:   state_d = ST_SAMPLE;
                ST_SAMPLE:  state_d = ST_RESOLVE;
                ST_RESOLVE: if (bit_q == '0) state_d = ST_SETTLE;
                ST_SETTLE:  if (set_q == SET_W'(SETTLE_TICKS - 1)) state_d = ST_XFER;
                ST_XFER:    state_d = cont_q ? ST_SAMPLE : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        sample_en = (state_q == ST_SAMPLE);
        done      = (state_q == ST_XFER) && adc_tick && !start;
        result    = acc_q;
        chan_sel  = chan_q;
        dac_code  = acc_q;
        if (state_q == ST_RESOLVE) dac_code = acc_q | (RES_W'(1) << bit_q);
    end

    // approximation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            set_q  <= '0;
            acc_q  <= '0;
            cont_q <= 1'b0;
            chan_q <= '0;
        end else begin
            if (start) begin
                cont_q <= cont_in;
                chan_q <= chan_in;
            end else if (adc_tick) begin
                case (state_q)
                    ST_SAMPLE: begin
                        acc_q <= '0;
                        bit_q <= IDX_W'(RES_W - 1);
                    end
                    ST_RESOLVE: begin
                        acc_q[bit_q] <= cmp_in;
                        if (bit_q != '0) bit_q <= bit_q - 1'b1;
                        set_q <= '0;
                    end
                    ST_SETTLE: set_q <= set_q + 1'b1;
                    default: begin end
                endcase
            end
        end
    end

    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_ALIGN));

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && adc_tick && !start) |=>
            (state_q == ST_RESOLVE && bit_q == IDX_W'(RES_W - 1)));

    assert_cont_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cont_q) |=> (state_q == ST_SAMPLE));

    assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cont_q) |=> !busy);

endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs
    import sar_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        fmt_in,
    input  logic              store,
    input  logic              rd,
    input  logic [RES_W-1:0]  raw,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              coco
);
    fmt_t              fmt_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_LEFT;
            data_q <= '0;
            coco   <= 1'b0;
        end else begin
            if (start) fmt_q <= fmt_t'(fmt_in);
            if (store) data_q <= pack_result(fmt_q, raw);
            // a completion beats a read in the same cycle
            if (start)      coco <= 1'b0;
            else if (store) coco <= 1'b1;
            else if (rd)    coco <= 1'b0;
        end
    end

    always_comb begin
        res_hi = data_q[DATA_W-1 -: BYTE_W];
        res_lo = data_q[BYTE_W-1:0];
    end

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !start) |=> coco);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !store && !start) |=> !coco);

    assert_write_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !coco);

    assert_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> $stable(data_q));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int CH_W         = 3,
    parameter int SETTLE_TICKS = 4,
    parameter int PRE_W        = 3,
    parameter int MAX_LOG      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             clk_sel,
    input  logic [PRE_W-1:0] prescale,
    input  logic             ctl_wr,
    input  logic             ctl_cont,
    input  logic [CH_W-1:0]  ctl_chan,
    input  logic [1:0]       ctl_fmt,
    input  logic             data_rd,
    input  logic             cmp_in,
    output logic [9:0]       dac_code,
    output logic [CH_W-1:0]  chan_sel,
    output logic             sample_en,
    output logic             busy,
    output logic             coco,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);
    logic             adc_tick;
    logic             done;
    logic [RES_W-1:0] result;

    adc_tick_gen #(.PRE_W(PRE_W), .MAX_LOG(MAX_LOG)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .ref_tick (ref_tick),
        .prescale (prescale),
        .adc_tick (adc_tick)
    );

    sar_seq #(.CH_W(CH_W), .SETTLE_TICKS(SETTLE_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_tick  (adc_tick),
        .start     (ctl_wr),
        .cont_in   (ctl_cont),
        .chan_in   (ctl_chan),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .result    (result),
        .chan_sel  (chan_sel),
        .sample_en (sample_en),
        .busy      (busy),
        .done      (done)
    );

    sar_result_regs u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ctl_wr),
        .fmt_in (ctl_fmt),
        .store  (done),
        .rd     (data_rd),
        .raw    (result),
        .res_hi (res_hi),
        .res_lo (res_lo),
        .coco   (coco)
    );

endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/100ps
module sar_adc_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       clk_sel = 1'b0;
    logic [2:0] prescale = 3'd0;
    logic       ctl_wr = 1'b0;
    logic       ctl_cont = 1'b0;
    logic [2:0] ctl_chan = 3'd0;
    logic [1:0] ctl_fmt = 2'd0;
    logic       data_rd = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;
    logic       sample_en, busy, coco;
    logic [7:0] res_hi, res_lo;

    int total = 0;
    int bad = 0;
    int vin = 0;
    int ref_cnt = 0;

    always #2.5 clk = ~clk;

    // ideal comparator
    assign cmp_in = (vin >= int'(dac_code));

    // reference tick: one cycle in three
    always @(negedge clk) begin
        ref_cnt  <= (ref_cnt == 2) ? 0 : ref_cnt + 1;
        ref_tick <= (ref_cnt == 2);
    end

    sar_adc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .clk_sel(clk_sel),
        .prescale(prescale), .ctl_wr(ctl_wr), .ctl_cont(ctl_cont),
        .ctl_chan(ctl_chan), .ctl_fmt(ctl_fmt), .data_rd(data_rd),
        .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
        .sample_en(sample_en), .busy(busy), .coco(coco),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_word(input int f, input int r);
        int r9;
        r9 = (r >> 9) & 1;
        case (f)
            0: return r << 6;
            1: return r;
            2: return (((1 - r9) << 9) | (r & 511)) << 6;
            default: return r >> 2;
        endcase
    endfunction

    task automatic issue_write(input bit cont, input int f);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_cont = cont; ctl_fmt = 2'(f); ctl_chan = ctl_chan + 3'd1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!coco && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_pulse;
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk(coco == 1'b0, "R12 reset coco", int'(coco), 0);
        chk(busy == 1'b0, "R12 reset busy", int'(busy), 0);
        chk({res_hi, res_lo} == 16'h0, "R12 reset data", int'({res_hi, res_lo}), 0);
    endtask

    task automatic t_length(input bit sel, input int pre, input int p);
        int n;
        clk_sel = sel; prescale = 3'(pre); vin = 613;
        issue_write(1'b0, 1);
        wait_done(n);
        chk(n >= 16*p + 1 && n <= 17*p, "R2/R3 conversion length", n, 16*p + 1);
        chk({res_hi, res_lo} == 16'(exp_word(1, 613)), "R4 result", int'({res_hi, res_lo}), 613);
        read_pulse();
    endtask

    task automatic t_exact17;
        int n;
        clk_sel = 1'b0; prescale = 3'd0; vin = 400;
        issue_write(1'b0, 1);
        wait_done(n);
        chk(n == 17, "R2 divide-1 length", n, 17);
        chk(chan_sel == ctl_chan, "R1 channel captured", int'(chan_sel), int'(ctl_chan));
        read_pulse();
    endtask

    task automatic t_format(input int f, input int v);
        int n;
        int e;
        clk_sel = 1'b0; prescale = 3'd0; vin = v;
        issue_write(1'b0, f);
        wait_done(n);
        e = exp_word(f, (v > 1023) ? 1023 : v);
        case (f)
            0: chk({res_hi, res_lo} == 16'(e), "R8 left", int'({res_hi, res_lo}), e);
            1: chk({res_hi, res_lo} == 16'(e), "R9 right", int'({res_hi, res_lo}), e);
            2: chk({res_hi, res_lo} == 16'(e), "R10 signed left", int'({res_hi, res_lo}), e);
            default: chk({res_hi, res_lo} == 16'(e), "R11 truncated", int'({res_hi, res_lo}), e);
        endcase
        read_pulse();
    endtask

    task automatic t_read;
        int n;
        int keep;
        clk_sel = 1'b0; prescale = 3'd0; vin = 77;
        issue_write(1'b0, 1);
        wait_done(n);
        chk(coco == 1'b1, "R7 flag set", int'(coco), 1);
        keep = int'({res_hi, res_lo});
        read_pulse();
        chk(coco == 1'b0, "R7 read clears", int'(coco), 0);
        chk(int'({res_hi, res_lo}) == keep, "R12 read keeps data", int'({res_hi, res_lo}), keep);
        // read lands on the completion edge
        vin = 88;
        issue_write(1'b0, 1);
        repeat (16) @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk(coco == 1'b1, "R7 same-cycle read keeps flag", int'(coco), 1);
        chk({res_hi, res_lo} == 16'd88, "R4 result 88", int'({res_hi, res_lo}), 88);
        read_pulse();
    endtask

    task automatic t_abort;
        int n;
        int prev;
        clk_sel = 1'b0; prescale = 3'd0;
        vin = 1023;
        issue_write(1'b0, 1);
        wait_done(n);
        chk(coco == 1'b1, "R1 flag before rewrite", int'(coco), 1);
        prev = int'({res_hi, res_lo});
        vin = 100;
        issue_write(1'b0, 1);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R1 busy mid conversion", int'(busy), 1);
        vin = 900;
        issue_write(1'b0, 1);
        chk(coco == 1'b0, "R1 write clears flag", int'(coco), 0);
        chk(int'({res_hi, res_lo}) == prev, "R1 data kept on abort", int'({res_hi, res_lo}), prev);
        wait_done(n);
        chk(n == 17, "R1 restart length", n, 17);
        chk({res_hi, res_lo} == 16'd900, "R1 restarted result", int'({res_hi, res_lo}), 900);
        read_pulse();
    endtask

    task automatic t_continuous;
        int n;
        clk_sel = 1'b0; prescale = 3'd1; vin = 300;
        issue_write(1'b1, 1);
        wait_done(n);
        chk(n >= 33 && n <= 34, "R2 first continuous length", n, 33);
        chk({res_hi, res_lo} == 16'd300, "R5 first result", int'({res_hi, res_lo}), 300);
        vin = 301;
        data_rd = 1'b1;
        n = 0;
        @(negedge clk);
        n = 1;
        data_rd = 1'b0;
        chk(coco == 1'b0, "R7 read clears in continuous", int'(coco), 0);
        while (!coco && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 32, "R5 completion spacing", n, 32);
        chk({res_hi, res_lo} == 16'd301, "R5 second result", int'({res_hi, res_lo}), 301);
        vin = 302;
        repeat (64) @(negedge clk);
        chk({res_hi, res_lo} == 16'd302, "R5 unread overwrite", int'({res_hi, res_lo}), 302);
        chk(busy == 1'b1, "R5 still running", int'(busy), 1);
        vin = 303;
        issue_write(1'b0, 1);
        wait_done(n);
        chk(n >= 33 && n <= 34, "R6 final length", n, 33);
        chk({res_hi, res_lo} == 16'd303, "R6 final result", int'({res_hi, res_lo}), 303);
        vin = 10;
        repeat (50) @(negedge clk);
        chk(busy == 1'b0, "R6 stopped", int'(busy), 0);
        chk(coco == 1'b1, "R12 flag held", int'(coco), 1);
        chk({res_hi, res_lo} == 16'd303, "R12 data held", int'({res_hi, res_lo}), 303);
        read_pulse();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact17();
        t_length(1'b0, 2, 4);
        t_length(1'b0, 3, 8);
        t_length(1'b0, 4, 16);
        t_length(1'b0, 7, 16);
        t_length(1'b1, 0, 3);
        t_length(1'b1, 1, 6);
        t_format(0, 709);
        t_format(1, 709);
        t_format(2, 709);
        t_format(2, 100);
        t_format(3, 709);
        t_format(1, 0);
        t_format(1, 5000);
        t_read();
        t_abort();
        t_continuous();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule